// File: doc/BRIEF.md
# Page-load and program sequencer

This block is the write engine of a small byte-wide nonvolatile memory, written as synchronous logic. Single-cycle write strobes bring an address and a data byte. The first write starts a page load. Later writes to the same page go into a page buffer. When no accepted write has arrived for a set number of cycles, the load window closes and a timed programming cycle begins. At the end of that cycle the loaded bytes are copied into the internal array.

While programming runs, the `busy` output is high and every read returns a status byte instead of stored data. In that byte, bit 7 is the inverse of bit 7 of the last byte accepted, and bit 6 alternates from one read to the next. A host can poll either bit to see when the cycle has ended. Once the cycle is over, reads return array contents again.

Top module: `page_prog_seq`

## Requirements
- R1: An address splits into a page index (the upper ADDR_W-PAGE_W bits) and a byte offset within the page (the low PAGE_W bits). When no cycle is running, a read of any address returns the byte last programmed there.
- R2: After reset, `busy` is 0, `rd_data` is 0 and every array byte reads 0.
- R3: A write while idle opens a load for its page. Loaded bytes are held in a buffer, and reads return the old array contents until programming completes.
- R4: Programming starts (`busy` goes to 1) exactly WIN_CYC clock edges after the edge that accepted the last write. Each accepted write restarts this count.
- R5: During a load, a write whose page index differs from the open page is dropped and does not restart the window count.
- R6: One load accepts at most 2**PAGE_W writes. Writes beyond that are dropped and do not restart the window count.
- R7: `busy` stays 1 for exactly PROG_CYC cycles. The array holds the new bytes from the first cycle after `busy` falls.
- R8: Writes while `busy` is 1 are dropped. They change neither the array nor the status byte.
- R9: While `busy` is 1, a read of any address returns bit 7 equal to the inverse of bit 7 of the last accepted byte, and bits 5..0 equal to that byte's bits 5..0. After completion, that byte reads back true.
- R10: While `busy` is 1, bit 6 of the status is 0 on the first read of the cycle and inverts on each further read.
- R11: Only offsets written during the load are updated. If an offset is written twice, the later byte is kept. All other bytes of the page keep their old values.
- R12: `rd_data` shows the result of a read one cycle after `rd_en`. It holds that value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_addr | input | ADDR_W | Write address: page index and byte offset |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read result: array byte, or status while busy |
| busy | output | 1 | Programming cycle in progress |

## Verification
The assertions rely on two things about the inputs: reset is held long enough for the array to clear, and the strobes are 0 or 1, never unknown. The window check also relies on the block's own accept decision, so it covers writes that the block drops as well as writes it takes. The bench drives every strobe for one full cycle, changing it on the falling clock edge, and it issues reads back to back while `busy` is high, so the bit 6 alternation property sees consecutive status reads. Dropped writes are placed both inside the load window and inside the programming cycle, so they reach the same timing checks as accepted writes.

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
  parameter int ADDR_W   = 9,
  parameter int PAGE_W   = 7,
  parameter int WIN_CYC  = 40,
  parameter int PROG_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int NBYTES = 1 << PAGE_W;
  localparam int WORDS  = 1 << ADDR_W;
  localparam int CNT_W  = PAGE_W + 1;
  localparam int WIN_W  = $clog2(WIN_CYC + 1);
  localparam int PRG_W  = $clog2(PROG_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} state_t;

  state_t            st;
  logic [PG_W-1:0]   pg;
  logic [CNT_W-1:0]  cnt;
  logic [WIN_W-1:0]  win;
  logic [PRG_W-1:0]  prg;
  logic [NBYTES-1:0] mask;
  logic [7:0]        last_b;
  logic              tgl;
  logic [7:0]        mem  [WORDS];
  logic [7:0]        pbuf [NBYTES];

  logic [PG_W-1:0]   wr_pg;
  logic [PAGE_W-1:0] wr_off;
  logic              acc;
  logic              commit;
  logic [7:0]        status;

  assign wr_pg  = wr_addr[ADDR_W-1:PAGE_W];
  assign wr_off = wr_addr[PAGE_W-1:0];
  assign acc    = wr_en && ((st == S_IDLE) ||
                  (st == S_LOAD && wr_pg == pg && cnt < CNT_W'(NBYTES)));
  assign busy   = (st == S_PROG);
  assign commit = busy && (prg == PRG_W'(PROG_CYC - 1));
  assign status = ((last_b ^ 8'h80) & 8'hBF) | {1'b0, tgl, 6'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pg     <= '0;
      cnt    <= '0;
      win    <= '0;
      prg    <= '0;
      mask   <= '0;
      last_b <= '0;
    end else if (acc) begin
      if (st == S_IDLE) begin
        pg   <= wr_pg;
        cnt  <= CNT_W'(1);
        mask <= NBYTES'(1) << wr_off;
      end else begin
        cnt          <= cnt + 1'b1;
        mask[wr_off] <= 1'b1;
      end
      win    <= '0;
      last_b <= wr_data;
      st     <= S_LOAD;
    end else if (st == S_LOAD) begin
      if (win == WIN_W'(WIN_CYC - 1)) begin
        st  <= S_PROG;
        prg <= '0;
      end else begin
        win <= win + 1'b1;
      end
    end else if (st == S_PROG) begin
      if (commit) st <= S_IDLE;
      else        prg <= prg + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) pbuf[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < WORDS; j++) mem[j] <= '0;
    end else if (commit) begin
      for (int i = 0; i < NBYTES; i++)
        if (mask[i]) mem[{pg, PAGE_W'(i)}] <= pbuf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      tgl     <= 1'b0;
    end else begin
      if (!busy) tgl <= 1'b0;
      else if (rd_en) tgl <= ~tgl;
      if (rd_en) rd_data <= busy ? status : mem[rd_addr];
    end
  end
endmodule

// File: rtl/page_prog_seq_chk.sv
module page_prog_seq_chk #(
  parameter int WIN_CYC  = 40,
  parameter int PROG_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic rd_en,
  input logic rd_b6,
  input logic acc
);
  localparam int QW = $clog2(WIN_CYC + 2);
  localparam int RW = $clog2(PROG_CYC + 2);

  logic [QW-1:0] quiet;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet <= '0;
      run   <= '0;
    end else begin
      if (acc) quiet <= '0;
      else if (quiet != QW'(WIN_CYC + 1)) quiet <= quiet + 1'b1;
      if (!busy) run <= '0;
      else if (run != RW'(PROG_CYC + 1)) run <= run + 1'b1;
    end
  end

  a_r4_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> quiet == QW'(WIN_CYC));

  a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(PROG_CYC));

  a_r7_busy_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == RW'(PROG_CYC));

  a_r10_status_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) ##1 (busy && rd_en) |=> rd_b6 != $past(rd_b6));
endmodule

bind page_prog_seq page_prog_seq_chk #(.WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_en(rd_en), .rd_b6(rd_data[6]), .acc(acc)
);

// File: tb/page_prog_seq_tb.sv
`timescale 1ns/1ps
module page_prog_seq_tb;
  localparam int AW = 9, PW = 7, WIN = 40, PRG = 100;
  localparam int NB = 1 << PW, NW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data, got;
  logic busy;
  logic [7:0] model [NW];
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  page_prog_seq #(.ADDR_W(AW), .PAGE_W(PW), .WIN_CYC(WIN), .PROG_CYC(PRG)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < PRG + 10 && busy; k++) @(negedge clk);
    check("R7 busy cleared", busy, 0);
  endtask

  function automatic logic [7:0] fa(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] fb(input int i);
    return 8'((i * 3 + 7) & 255);
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int j = 0; j < NW; j++) model[j] = 8'h00;
    step(4);
    rst_n = 1;
    step(1);
    // R2 reset state
    check("R2 busy after reset", busy, 0);
    check("R2 rd_data after reset", rd_data, 0);
    rd(9'd0, got);   check("R2 read addr 0", got, 0);
    rd(9'd511, got); check("R2 read addr 511", got, 0);

    // R3 R4: page 1 loaded fully, with a pause before the last byte
    for (int i = 0; i < NB - 1; i++) wr(9'(NB + i), fb(i));
    step(29);
    rd(9'(NB + 3), got);
    check("R3 old data during load", got, 0);
    check("R4 no busy before window ends", busy, 0);
    wr(9'(NB + NB - 1), fb(NB - 1));
    step(WIN - 1); check("R4 busy low at WIN-1", busy, 0);
    step(1);       check("R4 busy high at WIN", busy, 1);
    step(PRG - 1); check("R7 busy still high at PRG-1", busy, 1);
    step(1);       check("R7 busy low at PRG", busy, 0);
    for (int i = 0; i < NB; i++) model[NB + i] = fb(i);
    rd(9'(NB + 3), got); check("R7 new data after program", got, fb(3));

    // R5 R8 R9 R10 R11: sparse load of page 2
    wr(9'(2 * NB + 5), 8'h3C);
    wr(9'(2 * NB + 9), 8'h9A);
    wr(9'(2 * NB + 5), 8'hB5);
    step(10);
    wr(9'(3 * NB + 7), 8'hEE);
    step(WIN - 12); check("R5 mismatched page no restart, low", busy, 0);
    step(1);        check("R5 mismatched page no restart, high", busy, 1);
    wr(9'(2 * NB + 20), 8'h11);
    for (int k = 0; k < 4; k++) begin
      rd(9'(2 * NB + 5), got);
      check("R10 R9 status byte", got, {1'b0, 1'(k & 1), 6'h35});
    end
    rd(9'(2 * NB + 9), got);
    check("R9 status on other address", got, 8'h35);
    wait_idle();
    model[2 * NB + 5] = 8'hB5;
    model[2 * NB + 9] = 8'h9A;
    rd(9'(2 * NB + 5), got);  check("R9 true byte after completion", got, 8'hB5);
    rd(9'(2 * NB + 20), got); check("R8 write while busy dropped", got, 0);
    rd(9'(3 * NB + 7), got);  check("R5 other page untouched", got, 0);
    for (int i = 0; i < NB; i++) begin
      rd(9'(2 * NB + i), got);
      check("R11 page 2 sweep", got, model[2 * NB + i]);
    end

    // R6: full page 0 plus one extra write
    for (int i = 0; i < NB; i++) wr(9'(i), fa(i));
    wr(9'd0, 8'hFF);
    step(WIN - 2); check("R6 extra write no restart, low", busy, 0);
    step(1);       check("R6 extra write no restart, high", busy, 1);
    rd(9'd5, got);
    check("R9 status of last page-0 byte", got, (fa(NB - 1) ^ 8'h80) & 8'hBF);
    wait_idle();
    for (int i = 0; i < NB; i++) model[i] = fa(i);
    rd(9'd0, got); check("R6 extra byte dropped", got, fa(0));

    // R12 hold
    step(3);
    check("R12 rd_data held", rd_data, fa(0));

    // R1 full sweep
    for (int a = 0; a < NW; a++) begin
      rd(9'(a), got);
      check("R1 full array sweep", got, model[a]);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule